// File: doc/BRIEF.md
# Character-LCD Bus Interface Controller

This block takes instruction and data bytes from a host write port and sends them, in order, to an external character-LCD controller. Each byte enters a 16-entry transmit queue together with a tag bit. The tag later becomes the register-select line, so every queued byte knows whether it is an instruction or display data. A sequencer drains the queue onto one of three physical interfaces. The first is a parallel bus with an enable strobe and a read/write line (6800 style). The second is a parallel bus with separate active-low write and read strobes (8080 style). The third is a serial shifter with its own clock and data line.

The parallel bus can carry full bytes or nibble pairs. When polling is enabled, the sequencer reads the controller's status before every byte and waits until the busy bit clears. This means the host never has to poll. A level-based request output lets a DMA engine keep the queue topped up. All bus timing is counted in ticks of a programmable clock-enable divider, so the same block can serve both slow and fast panels.

Top module: `lcd_bus_ctrl`

## Requirements
- R1: Bytes leave the block in the order written, each with its own tag on `lcd_rs` (1 = data register, 0 = instruction register). The queue holds 16 entries.
- R2: With `cfg_mode`=2'b00 (6800 style), a write is a high pulse on `lcd_e` with `lcd_rw`=0, and the byte is taken on the falling edge of `lcd_e`. In this mode `lcd_wr_n` and `lcd_rd_n` stay high.
- R3: With `cfg_mode`=2'b01 (8080 style), a write is a low pulse on `lcd_wr_n`, and the byte is taken on its rising edge. In this mode `lcd_e` and `lcd_rw` stay 0.
- R4: With `cfg_nibble`=1 in a parallel mode, each byte goes out as two write strobes on `lcd_dout[7:4]`, upper nibble first, with `lcd_dout[3:0]`=0.
- R5: With a tick period of `cfg_div`+1 clocks, every parallel write behaves as follows: the data is driven (`lcd_doe`=1) one tick before the strobe asserts, the strobe stays active for two ticks, and the data is held one tick after release with an unchanged value.
- R6: With `cfg_mode[1]`=1 (serial), each byte is shifted out MSB first on `ser_dat`. Each bit is valid on the rising edge of `ser_clk`, giving eight rising edges per byte, and the tag is on `lcd_rs`. No parallel strobe moves and `lcd_doe` stays 0.
- R7: With `cfg_poll`=1 in a parallel mode, a status read (`lcd_rs`=0; `lcd_e` high with `lcd_rw`=1, or `lcd_rd_n` low) comes before each byte. The read repeats while `lcd_busy_in` is 1 when sampled during the strobe. `lcd_doe` is 0 throughout the read, and each byte takes one read in nibble mode too.
- R8: In serial mode `cfg_poll` has no effect, and no read strobe ever occurs.
- R9: `dma_req` is 1 exactly while the queue level is below `cfg_dma_lvl`. The level updates on the clock edge of a write, so `dma_req` reflects it from that same edge.
- R10: A write to a full queue is dropped and sets `ovf_flag`. The flag stays set until reset.
- R11: Once the queue is empty and the last transfer has ended, the bus is idle: `lcd_e`=0, `lcd_wr_n`=`lcd_rd_n`=1, `lcd_doe`=0, `ser_clk`=0.
- R12: After reset, the queue is empty, `ovf_flag`=0, all strobes are inactive and `lcd_doe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe that pushes one byte into the queue |
| host_data | input | 8 | Byte to queue |
| host_rs | input | 1 | Tag for the byte: 1 = data, 0 = instruction |
| cfg_mode | input | 2 | 00 = 6800 style, 01 = 8080 style, 1x = serial |
| cfg_nibble | input | 1 | 4-bit parallel transfers |
| cfg_poll | input | 1 | Poll the busy bit before each byte |
| cfg_div | input | DIV_W | Tick period minus one, in clocks |
| cfg_dma_lvl | input | LVL_W | Queue level below which `dma_req` is high |
| ovf_flag | output | 1 | Sticky overflow status |
| dma_req | output | 1 | Refill request |
| lcd_rs | output | 1 | Register select |
| lcd_rw | output | 1 | Read/write line, 6800 style |
| lcd_e | output | 1 | Enable strobe, 6800 style |
| lcd_wr_n | output | 1 | Active-low write strobe, 8080 style |
| lcd_rd_n | output | 1 | Active-low read strobe, 8080 style |
| lcd_dout | output | 8 | Data bus output value |
| lcd_doe | output | 1 | Data bus output enable |
| lcd_busy_in | input | 1 | Bus bit 7 read back during status reads |
| ser_clk | output | 1 | Serial clock |
| ser_dat | output | 1 | Serial data |

## Verification
The hardest situation to reach from the ports is a full queue while a transfer is still pending. Normally the sequencer keeps draining, so the level never stays at 16 for long. The bench enables polling and models a controller whose busy bit never clears. This parks the sequencer after it has taken exactly one byte. The bench can then step the level one entry at a time from 0 to 16 for several thresholds, and then overflow the queue. After that it releases the busy bit and checks that exactly the first seventeen bytes come out. The remaining configurations are swept in full: every mode, width, polling setting and two divider values.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    BUS_M68  = 2'b00,
    BUS_I80  = 2'b01,
    BUS_SER  = 2'b10,
    BUS_SER2 = 2'b11
  } bus_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RSET,
    ST_RSTB,
    ST_RHLD,
    ST_WSET,
    ST_WSTB,
    ST_WHLD,
    ST_SLO,
    ST_SHI
  } seq_state_e;

  typedef struct packed {
    logic              rs;
    logic [BYTE_W-1:0] data;
  } q_entry_t;

endpackage

// File: rtl/lcd_tick_gen.sv
module lcd_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  // One tick every div+1 clocks.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/lcd_tx_fifo.sv
module lcd_tx_fifo
  import lcd_bus_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  q_entry_t         push_ent,
  input  logic             pop,
  input  logic [LVL_W-1:0] thresh,
  output q_entry_t         head,
  output logic             empty,
  output logic             ovf,
  output logic             dma_req
);

  q_entry_t         mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [LVL_W-1:0] count, count_nxt;
  logic             full, push_ok, pop_ok;

  assign full    = (count == LVL_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_comb begin
    count_nxt = count + LVL_W'(push_ok) - LVL_W'(pop_ok);
  end

  // Storage without reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      ovf     <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count   <= count_nxt;
      ovf     <= ovf | (push && full);
      dma_req <= (count_nxt < thresh);
    end
  end

endmodule

// File: rtl/lcd_bus_seq.sv
module lcd_bus_seq
  import lcd_bus_pkg::*;
#(
  parameter int SETUP_TICKS  = 1,
  parameter int STROBE_TICKS = 2,
  parameter int HOLD_TICKS   = 1,
  localparam int PH_MAX = (SETUP_TICKS > STROBE_TICKS) ?
                          ((SETUP_TICKS > HOLD_TICKS) ? SETUP_TICKS : HOLD_TICKS) :
                          ((STROBE_TICKS > HOLD_TICKS) ? STROBE_TICKS : HOLD_TICKS),
  localparam int PH_W = $clog2(PH_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [1:0]        mode,
  input  logic              nibble,
  input  logic              poll,
  input  q_entry_t          head,
  input  logic              empty,
  input  logic              busy_in,
  output logic              pop,
  output logic              lcd_rs,
  output logic              lcd_rw,
  output logic              lcd_e,
  output logic              lcd_wr_n,
  output logic              lcd_rd_n,
  output logic [BYTE_W-1:0] lcd_dout,
  output logic              lcd_doe,
  output logic              ser_clk,
  output logic              ser_dat
);

  seq_state_e        state;
  q_entry_t          cur;
  logic [PH_W-1:0]   ph;
  logic              nib, busy;
  logic [2:0]        bitn;
  bus_mode_e         bm;
  logic              is_m68, is_ser;
  logic              setup_end, strobe_end, hold_end;

  assign bm         = bus_mode_e'(mode);
  assign is_m68     = (bm == BUS_M68);
  assign is_ser     = bm[1];
  assign setup_end  = (ph == PH_W'(SETUP_TICKS - 1));
  assign strobe_end = (ph == PH_W'(STROBE_TICKS - 1));
  assign hold_end   = (ph == PH_W'(HOLD_TICKS - 1));
  assign pop        = tick && (state == ST_IDLE) && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cur   <= '0;
      ph    <= '0;
      nib   <= 1'b0;
      bitn  <= 3'd7;
      busy  <= 1'b0;
    end else if (tick) begin
      case (state)
        ST_IDLE: if (!empty) begin
          cur  <= head;
          ph   <= '0;
          nib  <= 1'b0;
          bitn <= 3'd7;
          if (is_ser)    state <= ST_SLO;
          else if (poll) state <= ST_RSET;
          else           state <= ST_WSET;
        end
        ST_RSET: if (setup_end) begin ph <= '0; state <= ST_RSTB; end
                 else ph <= ph + 1'b1;
        ST_RSTB: if (strobe_end) begin
                   busy  <= busy_in;  // sampled in the last strobe tick
                   ph    <= '0;
                   state <= ST_RHLD;
                 end else ph <= ph + 1'b1;
        ST_RHLD: if (hold_end) begin
                   ph    <= '0;
                   state <= busy ? ST_RSET : ST_WSET;
                 end else ph <= ph + 1'b1;
        ST_WSET: if (setup_end) begin ph <= '0; state <= ST_WSTB; end
                 else ph <= ph + 1'b1;
        ST_WSTB: if (strobe_end) begin ph <= '0; state <= ST_WHLD; end
                 else ph <= ph + 1'b1;
        ST_WHLD: if (hold_end) begin
                   ph <= '0;
                   if (nibble && !nib) begin
                     nib   <= 1'b1;
                     state <= ST_WSET;
                   end else begin
                     state <= ST_IDLE;
                   end
                 end else ph <= ph + 1'b1;
        ST_SLO:  state <= ST_SHI;
        ST_SHI:  if (bitn == 3'd0) state <= ST_IDLE;
                 else begin
                   bitn  <= bitn - 1'b1;
                   state <= ST_SLO;
                 end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Output decode, registered below.
  logic              o_rs, o_rw, o_e, o_wr_n, o_rd_n, o_doe, o_sclk, o_sdat;
  logic [BYTE_W-1:0] o_dout;

  always_comb begin
    o_rs   = 1'b0;
    o_rw   = 1'b0;
    o_e    = 1'b0;
    o_wr_n = 1'b1;
    o_rd_n = 1'b1;
    o_doe  = 1'b0;
    o_dout = '0;
    o_sclk = 1'b0;
    o_sdat = 1'b0;
    case (state)
      ST_RSET, ST_RSTB, ST_RHLD: begin
        o_rw = is_m68;
        if (state == ST_RSTB) begin
          if (is_m68) o_e = 1'b1;
          else        o_rd_n = 1'b0;
        end
      end
      ST_WSET, ST_WSTB, ST_WHLD: begin
        o_rs  = cur.rs;
        o_doe = 1'b1;
        if (!nibble)  o_dout = cur.data;
        else if (nib) o_dout = {cur.data[3:0], 4'b0000};
        else          o_dout = {cur.data[7:4], 4'b0000};
        if (state == ST_WSTB) begin
          if (is_m68) o_e = 1'b1;
          else        o_wr_n = 1'b0;
        end
      end
      ST_SLO, ST_SHI: begin
        o_rs   = cur.rs;
        o_sdat = cur.data[bitn];
        o_sclk = (state == ST_SHI);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lcd_rs   <= 1'b0;
      lcd_rw   <= 1'b0;
      lcd_e    <= 1'b0;
      lcd_wr_n <= 1'b1;
      lcd_rd_n <= 1'b1;
      lcd_doe  <= 1'b0;
      lcd_dout <= '0;
      ser_clk  <= 1'b0;
      ser_dat  <= 1'b0;
    end else begin
      lcd_rs   <= o_rs;
      lcd_rw   <= o_rw;
      lcd_e    <= o_e;
      lcd_wr_n <= o_wr_n;
      lcd_rd_n <= o_rd_n;
      lcd_doe  <= o_doe;
      lcd_dout <= o_dout;
      ser_clk  <= o_sclk;
      ser_dat  <= o_sdat;
    end
  end

endmodule

// File: rtl/lcd_bus_ctrl.sv
module lcd_bus_ctrl
  import lcd_bus_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int DIV_W        = 8,
  parameter int SETUP_TICKS  = 1,
  parameter int STROBE_TICKS = 2,
  parameter int HOLD_TICKS   = 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [BYTE_W-1:0] host_data,
  input  logic              host_rs,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_nibble,
  input  logic              cfg_poll,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [LVL_W-1:0]  cfg_dma_lvl,
  output logic              ovf_flag,
  output logic              dma_req,
  output logic              lcd_rs,
  output logic              lcd_rw,
  output logic              lcd_e,
  output logic              lcd_wr_n,
  output logic              lcd_rd_n,
  output logic [BYTE_W-1:0] lcd_dout,
  output logic              lcd_doe,
  input  logic              lcd_busy_in,
  output logic              ser_clk,
  output logic              ser_dat
);

  q_entry_t push_ent, head;
  logic     tick, pop, empty;

  assign push_ent = '{rs: host_rs, data: host_data};

  lcd_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .div  (cfg_div),
    .tick (tick)
  );

  lcd_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .push     (host_wr),
    .push_ent (push_ent),
    .pop      (pop),
    .thresh   (cfg_dma_lvl),
    .head     (head),
    .empty    (empty),
    .ovf      (ovf_flag),
    .dma_req  (dma_req)
  );

  lcd_bus_seq #(
    .SETUP_TICKS  (SETUP_TICKS),
    .STROBE_TICKS (STROBE_TICKS),
    .HOLD_TICKS   (HOLD_TICKS)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .mode     (cfg_mode),
    .nibble   (cfg_nibble),
    .poll     (cfg_poll),
    .head     (head),
    .empty    (empty),
    .busy_in  (lcd_busy_in),
    .pop      (pop),
    .lcd_rs   (lcd_rs),
    .lcd_rw   (lcd_rw),
    .lcd_e    (lcd_e),
    .lcd_wr_n (lcd_wr_n),
    .lcd_rd_n (lcd_rd_n),
    .lcd_dout (lcd_dout),
    .lcd_doe  (lcd_doe),
    .ser_clk  (ser_clk),
    .ser_dat  (ser_dat)
  );

endmodule

// File: rtl/lcd_bus_ctrl_chk.sv
module lcd_bus_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cfg_mode,
  input logic       lcd_rs,
  input logic       lcd_rw,
  input logic       lcd_e,
  input logic       lcd_wr_n,
  input logic       lcd_rd_n,
  input logic [7:0] lcd_dout,
  input logic       lcd_doe,
  input logic       ovf_flag
);

  a_r2_m68_no_split_strobes: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'b00) |-> (lcd_wr_n && lcd_rd_n));

  a_r3_i80_no_enable: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'b01) |-> (!lcd_e && !lcd_rw));

  a_r6_serial_bus_quiet: assert property (@(posedge clk) disable iff (rst)
    cfg_mode[1] |-> (!lcd_e && lcd_wr_n && lcd_rd_n && !lcd_doe));

  a_r7_read_released: assert property (@(posedge clk) disable iff (rst)
    (!lcd_rd_n || (lcd_e && lcd_rw)) |-> !lcd_doe);

  a_r7_read_is_status: assert property (@(posedge clk) disable iff (rst)
    (!lcd_rd_n || (lcd_e && lcd_rw)) |-> !lcd_rs);

  a_r5_data_stable_wr: assert property (@(posedge clk) disable iff (rst)
    (!lcd_wr_n && !$past(lcd_wr_n)) |-> $stable(lcd_dout));

  a_r5_data_stable_e: assert property (@(posedge clk) disable iff (rst)
    (lcd_e && !lcd_rw && $past(lcd_e)) |-> $stable(lcd_dout));

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);

endmodule

bind lcd_bus_ctrl lcd_bus_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_mode (cfg_mode),
  .lcd_rs   (lcd_rs),
  .lcd_rw   (lcd_rw),
  .lcd_e    (lcd_e),
  .lcd_wr_n (lcd_wr_n),
  .lcd_rd_n (lcd_rd_n),
  .lcd_dout (lcd_dout),
  .lcd_doe  (lcd_doe),
  .ovf_flag (ovf_flag)
);

// File: tb/lcd_bus_ctrl_tb.sv
module lcd_bus_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0;
  logic [7:0] host_data = '0;
  logic       host_rs = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic       cfg_nibble = 1'b0;
  logic       cfg_poll = 1'b0;
  logic [7:0] cfg_div = '0;
  logic [4:0] cfg_dma_lvl = 5'd5;
  logic       ovf_flag, dma_req, lcd_rs, lcd_rw, lcd_e, lcd_wr_n, lcd_rd_n;
  logic [7:0] lcd_dout;
  logic       lcd_doe, lcd_busy_in, ser_clk, ser_dat;

  always #10 clk = ~clk;

  lcd_bus_ctrl u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_data(host_data), .host_rs(host_rs),
    .cfg_mode(cfg_mode), .cfg_nibble(cfg_nibble), .cfg_poll(cfg_poll), .cfg_div(cfg_div),
    .cfg_dma_lvl(cfg_dma_lvl), .ovf_flag(ovf_flag), .dma_req(dma_req), .lcd_rs(lcd_rs),
    .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n),
    .lcd_dout(lcd_dout), .lcd_doe(lcd_doe), .lcd_busy_in(lcd_busy_in),
    .ser_clk(ser_clk), .ser_dat(ser_dat)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // LCD model state
  logic [7:0] rx_d [64];
  logic       rx_rs [64];
  int         rx_n, reads, tmg_err, tmg_n, viol, busy_left, busy_cfg, tk, cyc_m;
  bit         busy_forever;
  logic [7:0] exp_d [64];
  logic       exp_rs [64];
  int         exp_n;

  assign lcd_busy_in = busy_forever || (busy_left > 0);

  logic       p_e, p_rw, p_wr_n, p_rd_n, p_doe, p_rs, p_sclk, p_w, p_r;
  logic [7:0] p_dout, last_w, sh;
  bit         w_now, r_now, nib_half, doe_fresh;
  logic [3:0] nib_hi;
  int         shn, t_doe_on, t_on, t_off;

  task automatic store(input logic [7:0] d, input logic rs);
    if (rx_n < 64) begin
      rx_d[rx_n]  = d;
      rx_rs[rx_n] = rs;
    end
    rx_n++;
    busy_left = busy_cfg;
  endtask

  always @(negedge clk) begin
    cyc_m++;
    w_now = (cfg_mode == 2'b00) ? (lcd_e && !lcd_rw) : ((cfg_mode == 2'b01) ? !lcd_wr_n : 1'b0);
    r_now = (cfg_mode == 2'b00) ? (lcd_e && lcd_rw)  : ((cfg_mode == 2'b01) ? !lcd_rd_n : 1'b0);
    if (!rst) begin
      if (r_now && lcd_doe) viol++;
      if (cfg_mode[1] && (lcd_e || !lcd_wr_n || !lcd_rd_n || lcd_doe)) viol++;
      if (cfg_mode == 2'b01 && (lcd_e || lcd_rw)) viol++;
      if (cfg_mode == 2'b00 && (!lcd_wr_n || !lcd_rd_n)) viol++;
      if (lcd_doe && !p_doe) begin t_doe_on = cyc_m; doe_fresh = 1; end
      if (w_now && !p_w) begin
        t_on = cyc_m;
        if (doe_fresh && (cyc_m - t_doe_on != tk)) tmg_err++;
      end
      if (!w_now && p_w) begin
        t_off = cyc_m;
        tmg_n++;
        if (cyc_m - t_on != 2 * tk) tmg_err++;
        doe_fresh = 0;
        last_w = p_dout;
        if (cfg_nibble) begin
          if (p_dout[3:0] != 4'h0) viol++;
          if (!nib_half) begin nib_hi = p_dout[7:4]; nib_half = 1; end
          else begin store({nib_hi, p_dout[7:4]}, p_rs); nib_half = 0; end
        end else begin
          store(p_dout, p_rs);
        end
      end
      if (!lcd_doe && p_doe) begin
        if (cyc_m - t_off != tk) tmg_err++;
        if (p_dout != last_w) tmg_err++;
      end
      if (!r_now && p_r) begin
        reads++;
        if (busy_left > 0) busy_left--;
        if (p_rs) viol++;
      end
      if (cfg_mode[1] && ser_clk && !p_sclk) begin
        sh = {sh[6:0], ser_dat};
        shn++;
        if (shn == 8) begin store(sh, lcd_rs); shn = 0; end
      end
    end
    p_e = lcd_e; p_rw = lcd_rw; p_wr_n = lcd_wr_n; p_rd_n = lcd_rd_n;
    p_doe = lcd_doe; p_rs = lcd_rs; p_sclk = ser_clk; p_dout = lcd_dout;
    p_w = w_now; p_r = r_now;
  end

  task automatic push(input logic [7:0] d, input logic rs, input bit keep);
    host_wr = 1'b1; host_data = d; host_rs = rs;
    if (keep) begin exp_d[exp_n] = d; exp_rs[exp_n] = rs; exp_n++; end
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic start(input int m, input bit nb, input bit pl, input int dv, input int lvl);
    rst = 1'b1;
    cfg_mode = 2'(m); cfg_nibble = nb; cfg_poll = pl; cfg_div = 8'(dv); cfg_dma_lvl = 5'(lvl);
    tk = dv + 1;
    busy_forever = 0; busy_cfg = pl ? 2 : 0; busy_left = busy_cfg;
    rx_n = 0; reads = 0; tmg_err = 0; tmg_n = 0; viol = 0; exp_n = 0;
    nib_half = 0; shn = 0; doe_fresh = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_rx(input int n);
    for (int k = 0; k < 8000 && rx_n < n; k++) @(negedge clk);
  endtask

  function automatic int mism();
    int c = 0;
    for (int i = 0; i < exp_n && i < 64; i++)
      if (rx_d[i] !== exp_d[i] || rx_rs[i] !== exp_rs[i]) c++;
    return c;
  endfunction

  task automatic run_case(input int m, input bit nb, input bit pl, input int dv);
    int mm;
    start(m, nb, pl, dv, 5);
    // R12: reset state (level 0 < 5 so request is high)
    chk(!lcd_e && lcd_wr_n && lcd_rd_n && !lcd_doe && !ser_clk && !ovf_flag && dma_req,
        "R12 reset state", int'({lcd_e, lcd_doe, ser_clk, ovf_flag}), 0);
    for (int i = 0; i < 12; i++)
      push(8'((m * 71 + nb * 13 + pl * 7 + dv * 3 + i * 29 + 11) & 255), ((i + m) % 3) == 0, 1'b1);
    wait_rx(12);
    repeat (30 * (dv + 1)) @(negedge clk);
    mm = mism();
    if (m == 0)      chk(rx_n == 12 && mm == 0, "R1 R2 6800 bytes and tags", rx_n - mm, 12);
    else if (m == 1) chk(rx_n == 12 && mm == 0, "R1 R3 8080 bytes and tags", rx_n - mm, 12);
    else             chk(rx_n == 12 && mm == 0, "R1 R6 serial bytes and tags", rx_n - mm, 12);
    chk(viol == 0, "R2 R3 R6 R7 strobe/enable discipline", viol, 0);
    if (m < 2) begin
      chk(tmg_err == 0 && tmg_n == 12 * (nb ? 2 : 1), "R5 setup/strobe/hold ticks", tmg_n - tmg_err, 12 * (nb ? 2 : 1));
      if (nb) chk(rx_n == 12 && mm == 0, "R4 nibble pairs upper first", rx_n - mm, 12);
      chk(reads == (pl ? 36 : 0), "R7 status reads per byte", reads, pl ? 36 : 0);
    end else begin
      chk(reads == 0, "R8 no poll in serial", reads, 0);
    end
    chk(!lcd_e && lcd_wr_n && lcd_rd_n && !lcd_doe && !ser_clk, "R11 idle after drain",
        int'({lcd_e, lcd_doe, ser_clk}), 0);
  endtask

  task automatic dma_case(input int lvl);
    start(0, 0, 1, 0, lvl);
    busy_forever = 1;
    push(8'hA5, 1'b1, 1'b1);
    repeat (10) @(negedge clk);   // byte taken, sequencer parked on busy
    for (int l = 0; l <= 16; l++) begin
      chk(dma_req == (l < lvl), "R9 request vs level", int'(dma_req), int'(l < lvl));
      if (l < 16) push(8'(l * 17 + 3), l[0], 1'b1);
    end
    chk(!ovf_flag, "R10 no overflow at exactly full", int'(ovf_flag), 0);
    for (int j = 0; j < 3; j++) push(8'(200 + j), 1'b0, 1'b0);
    chk(ovf_flag, "R10 overflow flag set", int'(ovf_flag), 1);
    busy_forever = 0;
    wait_rx(17);
    repeat (40) @(negedge clk);
    chk(rx_n == 17 && mism() == 0, "R10 dropped writes, R1 depth 16", rx_n, 17);
    push(8'h3C, 1'b0, 1'b1);
    wait_rx(18);
    repeat (20) @(negedge clk);
    chk(ovf_flag && rx_n == 18, "R10 flag sticky after later write", int'(ovf_flag), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int m = 0; m < 3; m++)
      for (int nb = 0; nb < 2; nb++)
        for (int pl = 0; pl < 2; pl++)
          for (int dv = 0; dv <= 2; dv += 2)
            run_case(m, nb[0], pl[0], dv);
    dma_case(0);
    dma_case(5);
    dma_case(16);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule